// File: doc/BRIEF.md
# Trap Delegation CSR Unit

This block holds the two machine-mode delegation registers of a core: a 64-bit exception delegation word and an interrupt delegation word sized to the data path. Each bit set in these registers marks one trap cause for handling in supervisor mode. The trap router reads the register outputs. Software reaches the registers through a single-cycle CSR port that carries an address, a write enable, write data, read data and an illegal-access flag. The port has no request strobe, so every clock cycle is an access to the presented address.

The exception delegation word is 64 bits wide on every configuration. With a 64-bit data path it sits behind one address. With a 32-bit data path its upper half has a separate address, and each write merges the new half with the half already stored. After the merge, the machine-mode environment-call cause is forced to zero. None of the addresses exists when the supervisor extension input is low.

Top module: `trap_deleg_csr`

## Requirements
- R1: After reset, reads of 0x302, 0x303 and (on a 32-bit path) 0x312 return zero.
- R2: 0x302 and 0x303 are legal only while the supervisor-enable input is high. 0x312 is legal only while that input is high and XLEN is 32. Any other address, and any address while the input is low, raises the illegal flag in the same cycle and returns zero read data.
- R3: A read of 0x302 returns bits XLEN-1..0 of the exception word. On a 32-bit path, a read of 0x312 returns bits 63..32.
- R4: On a 32-bit path, a write to 0x302 replaces bits 31..0 and keeps bits 63..32.
- R5: On a 32-bit path, a write to 0x312 replaces bits 63..32 and keeps bits 31..0.
- R6: Bit 11 of the exception word (environment call from machine mode) always reads zero. Every other written bit, such as bits 0, 1, 12, 13 and 15, is kept as written.
- R7: During a write cycle, the read data shows the legalised new content of the half being written.
- R8: A write to 0x303 stores all XLEN bits as written, bit 11 included.
- R9: A write takes effect at the clock edge that ends its cycle. A read in the next cycle returns the new value.
- R10: An illegal access, write or read, leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_ext_en | input | 1 | Supervisor extension present |
| csr_addr | input | 12 | CSR address of this cycle's access |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, or the written result during a write |
| csr_illegal | output | 1 | Address does not exist in the current configuration |
| edeleg_o | output | 64 | Exception delegation word to the trap router |
| ideleg_o | output | XLEN | Interrupt delegation word to the trap router |

## Verification
Read data and the illegal flag are combinational, so each is due in the cycle of its own access. A register update is due at the next rising edge and can be seen from the following cycle on. The driver presents each access just after a falling edge and queues the expected result. The monitor compares that result 2 ns later, still within the same cycle. Each access is followed by reads in later cycles, and those reads confirm the committed state, the kept half and the unchanged state after an illegal access.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam logic [11:0] ADDR_EXC_LO = 12'h302;
  localparam logic [11:0] ADDR_EXC_HI = 12'h312;
  localparam logic [11:0] ADDR_INT    = 12'h303;
  localparam int          EXC_W       = 64;
  localparam int          MECALL_POS  = 11;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ELO  = 2'd1,
    SEL_EHI  = 2'd2,
    SEL_INT  = 2'd3
  } csr_sel_e;

  function automatic logic [EXC_W-1:0] legalize_exc(input logic [EXC_W-1:0] v);
    logic [EXC_W-1:0] r;
    r             = v;
    r[MECALL_POS] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/tdc_decode.sv
module tdc_decode
  import tdc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [11:0] addr,
  input  logic        s_ext_en,
  output csr_sel_e    sel,
  output logic        illegal
);
  localparam bit HAS_HI = (XLEN == 32);

  always_comb begin
    sel = SEL_NONE;
    if (s_ext_en) begin
      if (addr == ADDR_EXC_LO)                sel = SEL_ELO;
      else if (addr == ADDR_INT)              sel = SEL_INT;
      else if (HAS_HI && addr == ADDR_EXC_HI) sel = SEL_EHI;
    end
    illegal = (sel == SEL_NONE);
  end
endmodule

// File: rtl/tdc_exc_reg.sv
module tdc_exc_reg
  import tdc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [XLEN-1:0]  wdata,
  output logic [EXC_W-1:0] d_o,
  output logic [EXC_W-1:0] q_o
);
  logic [EXC_W-1:0] q;
  logic [EXC_W-1:0] d;
  logic [EXC_W-1:0] merged_lo;
  logic [EXC_W-1:0] merged_hi;
  logic             en;

  generate
    if (XLEN == 32) begin : g_split
      assign merged_lo = {q[63:32], wdata};
      assign merged_hi = {wdata, q[31:0]};
    end else begin : g_full
      assign merged_lo = EXC_W'(wdata);
      assign merged_hi = q;
    end
  endgenerate

  always_comb begin
    en = wr_lo | wr_hi;
    d  = q;
    if (wr_lo)      d = legalize_exc(merged_lo);
    else if (wr_hi) d = legalize_exc(merged_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  assign d_o = d;
  assign q_o = q;

  a_r6_mecall_zero: assert property (@(posedge clk) disable iff (!rst_n)
    q[MECALL_POS] == 1'b0);

  generate
    if (XLEN == 32) begin : g_chk
      a_r4_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> q[63:32] == $past(q[63:32]));
      a_r5_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> q[31:0] == $past(q[31:0]));
    end
  endgenerate
endmodule

// File: rtl/tdc_int_reg.sv
module tdc_int_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] d_o,
  output logic [XLEN-1:0] q_o
);
  logic [XLEN-1:0] q;
  logic [XLEN-1:0] d;

  always_comb begin
    d = wr ? wdata : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= d;
  end

  assign d_o = d;
  assign q_o = q;

  a_r8_full_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(wdata));
endmodule

// File: rtl/trap_deleg_csr.sv
module trap_deleg_csr
  import tdc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_ext_en,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic [63:0]     edeleg_o,
  output logic [XLEN-1:0] ideleg_o
);
  csr_sel_e         sel;
  logic             illegal;
  logic             wr_lo, wr_hi, wr_int;
  logic [EXC_W-1:0] exc_d, exc_q;
  logic [XLEN-1:0]  int_d, int_q;
  logic [XLEN-1:0]  exc_hi_word;

  tdc_decode #(.XLEN(XLEN)) u_decode (
    .addr     (csr_addr),
    .s_ext_en (s_ext_en),
    .sel      (sel),
    .illegal  (illegal)
  );

  always_comb begin
    wr_lo  = csr_we && (sel == SEL_ELO);
    wr_hi  = csr_we && (sel == SEL_EHI);
    wr_int = csr_we && (sel == SEL_INT);
  end

  tdc_exc_reg #(.XLEN(XLEN)) u_exc (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (csr_wdata),
    .d_o   (exc_d),
    .q_o   (exc_q)
  );

  tdc_int_reg #(.XLEN(XLEN)) u_int (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_int),
    .wdata (csr_wdata),
    .d_o   (int_d),
    .q_o   (int_q)
  );

  generate
    if (XLEN == 32) begin : g_hi_view
      assign exc_hi_word = exc_d[63:32];
    end else begin : g_no_hi
      assign exc_hi_word = '0;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_ELO: csr_rdata = exc_d[XLEN-1:0];
      SEL_EHI: csr_rdata = exc_hi_word;
      SEL_INT: csr_rdata = int_d;
      default: csr_rdata = '0;
    endcase
    csr_illegal = illegal;
  end

  assign edeleg_o = exc_q;
  assign ideleg_o = int_q;

  a_r2_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0);
  a_r2_no_sext_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ext_en |-> csr_illegal);
  a_r10_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> (edeleg_o == $past(edeleg_o)) && (ideleg_o == $past(ideleg_o)));
endmodule

// File: tb/trap_deleg_csr_tb.sv
`timescale 1ns/1ps
module trap_deleg_csr_tb;
  localparam int XLEN = 32;

  logic            clk;
  logic            rst_n;
  logic            s_ext_en;
  logic [11:0]     csr_addr;
  logic            csr_we;
  logic [XLEN-1:0] csr_wdata;
  logic [XLEN-1:0] csr_rdata;
  logic            csr_illegal;
  logic [63:0]     edeleg_o;
  logic [XLEN-1:0] ideleg_o;

  trap_deleg_csr #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_ext_en(s_ext_en), .csr_addr(csr_addr),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .edeleg_o(edeleg_o), .ideleg_o(ideleg_o)
  );

  typedef struct {
    logic [XLEN-1:0] rd;
    logic            ill;
    string           tag;
  } exp_t;

  exp_t        sb[$];
  int          tests = 0;
  int          failed = 0;
  bit          done = 0;
  logic [63:0] m_exc = '0;
  logic [31:0] m_int = '0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic access(input logic [11:0] a, input logic we, input logic [31:0] wd,
                        input logic s, input string tag);
    exp_t e;
    bit   legal;
    @(negedge clk);
    s_ext_en  = s;
    csr_addr  = a;
    csr_we    = we;
    csr_wdata = wd;
    legal = s && (a == 12'h302 || a == 12'h303 || a == 12'h312);
    e.tag = tag;
    e.ill = !legal;
    e.rd  = '0;
    if (legal) begin
      if (a == 12'h302) begin
        if (we) begin m_exc[31:0] = wd; m_exc[11] = 1'b0; end
        e.rd = m_exc[31:0];
      end else if (a == 12'h312) begin
        if (we) m_exc[63:32] = wd;
        e.rd = m_exc[63:32];
      end else begin
        if (we) m_int = wd;
        e.rd = m_int;
      end
    end
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    s_ext_en = 1'b1;
    csr_addr = 12'h303;
    csr_we   = 1'b0;
    csr_wdata = '0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        tests++;
        if (csr_rdata !== e.rd || csr_illegal !== e.ill) begin
          failed++;
          $display("FAIL %s: rdata=%h illegal=%b expected rdata=%h illegal=%b",
                   e.tag, csr_rdata, csr_illegal, e.rd, e.ill);
        end
      end
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; s_ext_en = 1'b1; csr_addr = 12'h303; csr_we = 1'b0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    access(12'h302, 0, 0, 1, "R1");
    access(12'h312, 0, 0, 1, "R1");
    access(12'h303, 0, 0, 1, "R1");
    // R6 R7 write low half, bit 11 cleared in echo
    access(12'h302, 1, 32'hFFFF_FFFF, 1, "R7_R6");
    access(12'h302, 0, 0, 1, "R9_R3");
    access(12'h312, 0, 0, 1, "R4");
    // R5 write high half keeps low
    access(12'h312, 1, 32'hA5A5_5A5A, 1, "R7");
    access(12'h302, 0, 0, 1, "R5");
    access(12'h312, 0, 0, 1, "R3_R9");
    // R6 named causes kept, R4 high kept
    access(12'h302, 1, 32'h0000_B003, 1, "R6");
    access(12'h312, 0, 0, 1, "R4");
    access(12'h302, 1, 32'h0000_0800, 1, "R6");
    access(12'h302, 0, 0, 1, "R6");
    // R8 interrupt word unmasked
    access(12'h303, 1, 32'hFFFF_FFFF, 1, "R8");
    access(12'h303, 0, 0, 1, "R8");
    access(12'h303, 1, 32'h0000_0800, 1, "R8");
    access(12'h303, 0, 0, 1, "R8_R9");
    // R2 R10 illegal address
    access(12'h304, 1, 32'h1234_5678, 1, "R2");
    access(12'h313, 1, 32'hFFFF_FFFF, 1, "R2");
    access(12'h312, 0, 0, 1, "R10");
    access(12'h303, 0, 0, 1, "R10");
    // R2 R10 supervisor extension absent
    access(12'h302, 0, 0, 0, "R2");
    access(12'h303, 1, 32'hDEAD_BEEF, 0, "R2");
    access(12'h312, 1, 32'h0BAD_F00D, 0, "R2");
    access(12'h303, 0, 0, 1, "R10");
    access(12'h312, 0, 0, 1, "R10");
    // R4 R5 final merge
    access(12'h312, 1, 32'h0000_0001, 1, "R5");
    access(12'h302, 0, 0, 1, "R5");
    idle();
    idle();
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule